// File: doc/BRIEF.md
# Two-Edge Delay-Line Snapshot Decoder

This block sits behind a clock-sampled tapped delay line whose hit input fires a short wave rather than a single step. Each captured snapshot therefore holds two transitions caused by the same hit: a falling boundary (ones followed by zeros, counting upward from tap 0) and, further along the line, a rising boundary (zeros followed by ones). The decoder locates both boundaries. It checks that their spacing lies inside a configured window. It then adds the two positions into a single fine code that is one bit wider than a position. The sum is twice the mean of the two positions, so the code keeps half-tap precision and narrows the wide bins that one edge alone would give.

When a snapshot holds no usable pair, the block raises an error flag and falls back to twice the first-edge position. If there is no first edge, the fallback code is zero. The decode runs through a fixed four-register pipeline, so every accepted snapshot produces exactly one result a constant number of cycles later.

Top module: `wu_decoder`

## Requirements
- R1: The first edge position p is the lowest index p >= 1 with tap[p-1]=1 and tap[p]=0. A rising boundary below p has no effect on it.
- R2: The second edge position q is the lowest index q > p with tap[q-1]=0 and tap[q]=1. Any later boundaries are ignored.
- R3: When both edges exist and GAP_MIN <= q-p <= GAP_MAX (inclusive), fine_code equals p+q and edge_err is 0.
- R4: When both edges exist but q-p lies outside that window, edge_err is 1 and fine_code equals 2*p.
- R5: When the first edge exists but no second edge follows it, edge_err is 1 and fine_code equals 2*p.
- R6: When the snapshot has no falling boundary at all, edge_err is 1 and fine_code equals 0.
- R7: A snapshot with in_valid sampled high at rising edge n gives out_valid high for exactly the one cycle after edge n+3. Each snapshot gives exactly one result, and a cycle with in_valid low gives none.
- R8: While rst is high at a rising edge, out_valid and edge_err are 0 after that edge.
- R9: edge_err is never 1 while out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A snapshot is present on taps this cycle |
| taps | input | TAPS (256) | Captured delay-line state, bit 0 nearest the launch point |
| out_valid | output | 1 | fine_code and edge_err hold a result |
| fine_code | output | POS_W+1 (9) | Sum of both edge positions, or the fallback code |
| edge_err | output | 1 | The snapshot did not yield a spaced pair of edges |

## Verification
The bench builds the decoder with 256 taps and a spacing window of 4 to 64 taps. With these values it can drive pairs exactly at both window limits and one tap beyond each limit, and it can place edges near the top of the line where p+q approaches the 9-bit maximum. The spacing window is narrow relative to the line, so random wave snapshots fall on both sides of it. Back-to-back snapshots mixed with idle cycles exercise the constant latency and the one-result-per-snapshot rule.

// File: rtl/wu_pkg.sv
package wu_pkg;
   // Outcome of the edge-pair decode for one snapshot
   typedef enum logic [1:0] {
      WU_PAIR_OK  = 2'd0,
      WU_GAP_BAD  = 2'd1,
      WU_SINGLE   = 2'd2,
      WU_NO_EDGE  = 2'd3
   } wu_class_e;
endpackage

// File: rtl/wu_edge_mark.sv
module wu_edge_mark #(
   parameter int N = 256
) (
   input  logic [N-1:0] taps,
   output logic [N-1:0] fall,
   output logic [N-1:0] rise
);
   // Bit 0 has no predecessor, so it never marks a boundary
   assign fall[0] = 1'b0;
   assign rise[0] = 1'b0;

   for (genvar i = 1; i < N; i++) begin : g_mark
      assign fall[i] =  taps[i-1] & ~taps[i];
      assign rise[i] = ~taps[i-1] &  taps[i];
   end
endmodule

// File: rtl/wu_lsb_enc.sv
module wu_lsb_enc #(
   parameter int N  = 256,
   parameter int IW = $clog2(N)
) (
   input  logic [N-1:0]  vec,
   output logic [IW-1:0] idx,
   output logic          found
);
   always_comb begin
      idx   = '0;
      found = 1'b0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) begin
            idx   = IW'(i);
            found = 1'b1;
         end
      end
   end
endmodule

// File: rtl/wu_merge.sv
module wu_merge
   import wu_pkg::*;
#(
   parameter int POS_W   = 8,
   parameter int GAP_MIN = 4,
   parameter int GAP_MAX = 64
) (
   input  logic [POS_W-1:0] p_first,
   input  logic             first_ok,
   input  logic [POS_W-1:0] p_second,
   input  logic             second_ok,
   output logic [POS_W:0]   code,
   output wu_class_e        cls
);
   logic [POS_W-1:0] gap;
   logic             gap_in;

   assign gap    = p_second - p_first;
   assign gap_in = (int'(gap) >= GAP_MIN) && (int'(gap) <= GAP_MAX);

   always_comb begin
      if (!first_ok) begin
         cls  = WU_NO_EDGE;
         code = '0;
      end else if (!second_ok) begin
         cls  = WU_SINGLE;
         code = {p_first, 1'b0};
      end else if (!gap_in) begin
         cls  = WU_GAP_BAD;
         code = {p_first, 1'b0};
      end else begin
         cls  = WU_PAIR_OK;
         code = {1'b0, p_first} + {1'b0, p_second};
      end
   end
endmodule

// File: rtl/wu_decoder.sv
module wu_decoder
   import wu_pkg::*;
#(
   parameter int TAPS    = 256,
   parameter int GAP_MIN = 4,
   parameter int GAP_MAX = 64
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   in_valid,
   input  logic [TAPS-1:0]        taps,
   output logic                   out_valid,
   output logic [$clog2(TAPS):0]  fine_code,
   output logic                   edge_err
);
   localparam int POS_W  = $clog2(TAPS);
   localparam int CODE_W = POS_W + 1;

   // Elaboration-time parameter checks
   if (TAPS < 4) begin : g_bad_taps
      $error("wu_decoder: TAPS must be at least 4");
   end
   if (GAP_MIN < 1 || GAP_MAX < GAP_MIN) begin : g_bad_window
      $error("wu_decoder: need 1 <= GAP_MIN <= GAP_MAX");
   end
   if (GAP_MAX >= TAPS) begin : g_bad_gapmax
      $error("wu_decoder: GAP_MAX must be below TAPS");
   end

   // Stage 0: capture snapshot
   logic            s0_v;
   logic [TAPS-1:0] s0_taps;

   always_ff @(posedge clk) begin
      if (rst) begin
         s0_v    <= 1'b0;
         s0_taps <= '0;
      end else begin
         s0_v    <= in_valid;
         s0_taps <= taps;
      end
   end

   // Stage 1: boundary marks and first-edge search
   logic [TAPS-1:0]  fall_c, rise_c;
   logic [POS_W-1:0] first_c;
   logic             first_ok_c;

   wu_edge_mark #(.N(TAPS)) mark_i (
      .taps (s0_taps),
      .fall (fall_c),
      .rise (rise_c)
   );

   wu_lsb_enc #(.N(TAPS), .IW(POS_W)) enc_first_i (
      .vec   (fall_c),
      .idx   (first_c),
      .found (first_ok_c)
   );

   logic             s1_v;
   logic [TAPS-1:0]  s1_rise;
   logic [POS_W-1:0] s1_first;
   logic             s1_first_ok;

   always_ff @(posedge clk) begin
      if (rst) begin
         s1_v        <= 1'b0;
         s1_rise     <= '0;
         s1_first    <= '0;
         s1_first_ok <= 1'b0;
      end else begin
         s1_v        <= s0_v;
         s1_rise     <= rise_c;
         s1_first    <= first_c;
         s1_first_ok <= first_ok_c;
      end
   end

   // Stage 2: second-edge search above the first edge
   logic [TAPS-1:0]  above;
   logic [TAPS-1:0]  rise_above;
   logic [POS_W-1:0] second_c;
   logic             second_ok_c;

   for (genvar j = 0; j < TAPS; j++) begin : g_above
      assign above[j] = (j > int'(s1_first));
   end
   assign rise_above = s1_rise & above;

   wu_lsb_enc #(.N(TAPS), .IW(POS_W)) enc_second_i (
      .vec   (rise_above),
      .idx   (second_c),
      .found (second_ok_c)
   );

   logic             s2_v;
   logic [POS_W-1:0] s2_first, s2_second;
   logic             s2_first_ok, s2_second_ok;

   always_ff @(posedge clk) begin
      if (rst) begin
         s2_v         <= 1'b0;
         s2_first     <= '0;
         s2_second    <= '0;
         s2_first_ok  <= 1'b0;
         s2_second_ok <= 1'b0;
      end else begin
         s2_v         <= s1_v;
         s2_first     <= s1_first;
         s2_second    <= second_c;
         s2_first_ok  <= s1_first_ok;
         s2_second_ok <= s1_first_ok & second_ok_c;
      end
   end

   // Stage 3: spacing check and combine
   logic [CODE_W-1:0] code_c;
   wu_class_e         cls_c;

   wu_merge #(.POS_W(POS_W), .GAP_MIN(GAP_MIN), .GAP_MAX(GAP_MAX)) merge_i (
      .p_first   (s2_first),
      .first_ok  (s2_first_ok),
      .p_second  (s2_second),
      .second_ok (s2_second_ok),
      .code      (code_c),
      .cls       (cls_c)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         fine_code <= '0;
         edge_err  <= 1'b0;
      end else begin
         out_valid <= s2_v;
         fine_code <= code_c;
         edge_err  <= s2_v && (cls_c != WU_PAIR_OK);
      end
   end
endmodule

// File: rtl/wu_decoder_chk.sv
module wu_decoder_chk #(
   parameter int CODE_W  = 9,
   parameter int GAP_MIN = 4
) (
   input logic              clk,
   input logic              rst,
   input logic              in_valid,
   input logic              out_valid,
   input logic [CODE_W-1:0] fine_code,
   input logic              edge_err
);
   logic [3:0] vtrack;

   always_ff @(posedge clk) begin
      if (rst) vtrack <= '0;
      else     vtrack <= {vtrack[2:0], in_valid};
   end

   // R7: result appears a fixed number of cycles after each accepted snapshot
   assert_latency_R7: assert property (@(posedge clk) disable iff (rst)
      out_valid == vtrack[3]);

   // R9: error only alongside a result
   assert_err_with_valid_R9: assert property (@(posedge clk) disable iff (rst)
      edge_err |-> out_valid);

   // R4 / R5 / R6: every fallback code is an even number
   assert_fallback_even_R4: assert property (@(posedge clk) disable iff (rst)
      (out_valid && edge_err) |-> !fine_code[0]);

   // R3: a good pair has p >= 1 and q >= p + GAP_MIN
   assert_pair_floor_R3: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !edge_err) |-> (int'(fine_code) >= 2 + GAP_MIN));

   // R8: reset clears the outputs
   assert_reset_clear_R8: assert property (@(posedge clk)
      rst |=> (!out_valid && !edge_err));
endmodule

bind wu_decoder wu_decoder_chk #(.CODE_W(CODE_W), .GAP_MIN(GAP_MIN)) chk_i (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .out_valid (out_valid),
   .fine_code (fine_code),
   .edge_err  (edge_err)
);

// File: tb/wu_decoder_tb.sv
module wu_decoder_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int TAPS    = 256;
   localparam int GAP_MIN = 4;
   localparam int GAP_MAX = 64;
   localparam int CODE_W  = $clog2(TAPS) + 1;

   typedef struct {
      logic [CODE_W-1:0] code;
      logic              err;
      int                stamp;
      string             tag;
   } exp_t;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              in_valid = 1'b0;
   logic [TAPS-1:0]   taps = '0;
   logic              out_valid;
   logic [CODE_W-1:0] fine_code;
   logic              edge_err;

   int   cyc = 0;
   int   n_checks = 0;
   int   n_fail = 0;
   exp_t sb[$];

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   wu_decoder #(.TAPS(TAPS), .GAP_MIN(GAP_MIN), .GAP_MAX(GAP_MAX)) dut_i (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .taps      (taps),
      .out_valid (out_valid),
      .fine_code (fine_code),
      .edge_err  (edge_err)
   );

   // ones on [0,a), zeros on [a,b), ones on [b,c), zeros from c on
   function automatic logic [TAPS-1:0] pat(int a, int b, int c);
      logic [TAPS-1:0] v;
      for (int i = 0; i < TAPS; i++) v[i] = (i < a) || (i >= b && i < c);
      return v;
   endfunction

   // Reference decode written from R1..R6
   function automatic void ref_decode(logic [TAPS-1:0] t,
                                      output logic [CODE_W-1:0] code,
                                      output logic err);
      int p, q;
      p = -1; q = -1;
      for (int i = 1; i < TAPS; i++)
         if (p < 0 && t[i-1] && !t[i]) p = i;
      if (p > 0)
         for (int j = p + 1; j < TAPS; j++)
            if (q < 0 && !t[j-1] && t[j]) q = j;
      if (p < 0) begin
         code = '0; err = 1'b1;
      end else if (q < 0 || (q - p) < GAP_MIN || (q - p) > GAP_MAX) begin
         code = CODE_W'(2 * p); err = 1'b1;
      end else begin
         code = CODE_W'(p + q); err = 1'b0;
      end
   endfunction

   // Driver: presents one snapshot and queues what must come out
   task automatic send(logic [TAPS-1:0] t, int code, bit err, string tag);
      exp_t e;
      @(negedge clk);
      in_valid = 1'b1;
      taps     = t;
      e.code   = CODE_W'(code);
      e.err    = err;
      e.stamp  = cyc + 4;
      e.tag    = tag;
      sb.push_back(e);
   endtask

   task automatic idle(int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         in_valid = 1'b0;
         taps     = '1;
      end
   endtask

   // Monitor: compares results against the queue away from the active edge
   always @(negedge clk) begin
      if (!rst) begin
         n_checks++;
         if (edge_err && !out_valid) begin
            n_fail++;
            $display("FAIL R9: edge_err=%0b with out_valid=%0b expected 0", edge_err, out_valid);
         end
         if (out_valid) begin
            exp_t e;
            if (sb.size() == 0) begin
               n_fail++;
               $display("FAIL R7: unexpected result code=%0d at cycle %0d, expected none", fine_code, cyc);
            end else begin
               e = sb.pop_front();
               n_checks++;
               if (e.stamp != cyc) begin
                  n_fail++;
                  $display("FAIL R7: result at cycle %0d expected at cycle %0d", cyc, e.stamp);
               end
               if (fine_code !== e.code || edge_err !== e.err) begin
                  n_fail++;
                  $display("FAIL %s: code=%0d err=%0b expected code=%0d err=%0b",
                           e.tag, fine_code, edge_err, e.code, e.err);
               end
            end
         end else if (sb.size() != 0 && sb[0].stamp <= cyc) begin
            n_fail++;
            $display("FAIL R7: out_valid=0 at cycle %0d, expected 1 (%s)", cyc, sb[0].tag);
            void'(sb.pop_front());
         end
      end
   end

   // Watchdog
   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      logic [CODE_W-1:0] rc;
      logic              re;
      logic [TAPS-1:0]   t;

      // R8: outputs cleared while in reset, with a snapshot driven
      @(negedge clk);
      in_valid = 1'b1;
      taps     = pat(10, 20, 40);
      repeat (5) @(negedge clk);
      n_checks++;
      if (out_valid !== 1'b0 || edge_err !== 1'b0) begin
         n_fail++;
         $display("FAIL R8: out_valid=%0b edge_err=%0b expected 0 0", out_valid, edge_err);
      end
      in_valid = 1'b0;
      rst      = 1'b0;
      idle(6);

      // Directed cases
      send(pat(10, 20, 40),   30,  0, "R3");   // plain pair
      send(pat(10, 14, 30),   24,  0, "R3");   // gap at lower limit
      send(pat(10, 13, 30),   20,  1, "R4");   // gap one below limit
      send(pat(10, 74, 100),  84,  0, "R3");   // gap at upper limit
      idle(2);
      send(pat(10, 75, 100),  20,  1, "R4");   // gap one above limit
      send(pat(37, 0, 0),     74,  1, "R5");   // single falling edge
      send(pat(0, 0, 0),      0,   1, "R6");   // all zeros
      send(pat(256, 0, 0),    0,   1, "R6");   // all ones
      send(pat(0, 50, 256),   0,   1, "R6");   // only a rising boundary
      idle(3);
      send(pat(0, 5, 9),      18,  1, "R1");   // rise below the first fall ignored
      send(pat(200, 240, 256), 440, 0, "R3");  // high positions
      send(pat(250, 255, 256), 505, 0, "R3");  // near the top of the line
      send(pat(10, 20, 30) | pat(0, 40, 256), 30, 0, "R2"); // later edges ignored
      send(pat(10, 12, 13) | pat(0, 30, 256), 20, 1, "R2"); // nearest rise decides
      idle(1);

      // Random wave snapshots, mixed with idle cycles
      for (int k = 0; k < 300; k++) begin
         int a, b, c;
         a = 1 + int'($urandom_range(0, 199));
         b = a + 1 + int'($urandom_range(0, 79));
         c = b + 1 + int'($urandom_range(0, 60));
         if (k % 10 == 7) t = {$urandom, $urandom, $urandom, $urandom,
                               $urandom, $urandom, $urandom, $urandom};
         else t = pat(a, b, c);
         ref_decode(t, rc, re);
         send(t, int'(rc), re, re ? "R4" : "R3");
         if ($urandom_range(0, 3) == 0) idle(int'($urandom_range(1, 3)));
      end
      idle(10);

      // R7: nothing left pending and nothing produced without a snapshot
      n_checks++;
      if (sb.size() != 0) begin
         n_fail++;
         $display("FAIL R7: %0d results missing, expected 0", sb.size());
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule